// File: doc/BRIEF.md
# Sub-word Load/Store Data Aligner

This block sits between a 32-bit processor core and a data memory that is addressed by whole words. On a store it takes the source register, copies its low byte or low halfword into every lane where it could land, and raises only the byte write enables that cover the addressed lane. On a load it keeps the access shape of the request for one cycle. When the memory word comes back, it picks out the addressed byte or halfword and widens it to 32 bits, filling the upper bits with either the sign bit or zeros.

Lanes are numbered big-endian. Address offset 0 names the most significant byte, bits 31:24. The block does not compute addresses, does not model memory timing and does not take exceptions. It only flags an access that is not aligned to its own size and holds back the write enables for that access.

Top module: `sw_mem_aligner`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the first cycle after it, `ld_valid` is 0.
- R2: A signed byte load (`req_size`=2'b00, `req_unsigned`=0) returns the byte at offset k, which is bits [31-8k:24-8k] of `mem_rdata`, with bits 31:8 set to a copy of that byte's bit 7.
- R3: An unsigned byte load (`req_size`=2'b00, `req_unsigned`=1) returns the same selected byte with bits 31:8 cleared.
- R4: A signed halfword load (`req_size`=2'b01) returns `mem_rdata[31:16]` for offset 0 or `mem_rdata[15:0]` for offset 2, with bits 31:16 copied from bit 15 of that half.
- R5: An unsigned halfword load returns the same selected half with bits 31:16 cleared.
- R6: A word load (`req_size`=2'b10, or the spare code 2'b11, which acts as a word) returns `mem_rdata` unchanged, whatever the value of `req_unsigned`.
- R7: The load result is presented in the cycle after the request. `ld_valid` is 1 there exactly when the previous cycle held a load request (`req_valid`=1, `req_write`=0) that was aligned. `mem_rdata` is sampled in that same cycle.
- R8: A byte store drives `mem_wdata` with `st_src[7:0]` in all four lanes. Bit i of `mem_be` covers bits 8i+7:8i, and only bit 3-k is set for offset k.
- R9: A halfword store drives `mem_wdata` = {`st_src[15:0]`, `st_src[15:0]`}. `mem_be` is 4'b1100 for offset 0 and 4'b0011 for offset 2.
- R10: A word store drives `mem_wdata` = `st_src` and `mem_be` = 4'b1111.
- R11: `misaligned` is raised in the request cycle for a halfword at an odd offset and for a word at any nonzero offset; a byte is never flagged. A flagged access has `mem_be` = 0 and gives no `ld_valid` in the next cycle.
- R12: With `req_valid` low, `mem_be` is 0 and `misaligned` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Load widens with zeros instead of the sign bit |
| req_offset | input | 2 | Low address bits, the byte offset within the word |
| st_src | input | 32 | Store source register |
| mem_wdata | output | 32 | Lane-replicated store data to memory |
| mem_be | output | 4 | Byte write enables, bit 3 = bits 31:24 |
| misaligned | output | 1 | Access not aligned to its size |
| mem_rdata | input | 32 | Memory word returned the cycle after a load request |
| ld_valid | output | 1 | `ld_data` holds a load result this cycle |
| ld_data | output | 32 | Extracted and widened load result |

## Verification
Directed loads use words whose selected lane has its top bit set and words where it is clear. Because each lane of such a word holds a distinct value, these loads show that the right lane was chosen and that sign fill and zero fill differ where they should. Stores use a source whose upper bytes differ from its low byte, so any leak of the high register bits into the written lanes shows up. Random requests of every size, offset, direction and signedness are run back to back, with idle cycles between them. They mix aligned and misaligned shapes, which tests the enable masks and the suppression of `ld_valid` against a bench model. A spare-size request and a word load with `req_unsigned` set confirm that both fall back to plain word behaviour.

// File: rtl/sw_align_pkg.sv
// Package: shared access-size encoding for the sub-word aligner.
// Assumes a two-bit size field from the core; the spare code acts as a word.
package sw_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_SPARE = 2'b11
    } acc_size_e;

    // Collapse the spare code onto the word shape.
    function automatic acc_size_e norm_size(input logic [1:0] raw);
        acc_size_e s;
        s = acc_size_e'(raw);
        if (s == SZ_SPARE) s = SZ_WORD;
        return s;
    endfunction

endpackage

// File: rtl/sw_misalign_detect.sv
// Module: flags an access whose offset is not a multiple of its size.
// Assumes the size is already normalised; a byte access is always aligned.
module sw_misalign_detect
    import sw_align_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  acc_size_e         size_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic              bad_o
);

    // Compare the offset bits that must be zero for the given size.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: bad_o = 1'b0;
            SZ_HALF: bad_o = off_i[0];
            default: bad_o = |off_i;
        endcase
    end

endmodule

// File: rtl/sw_store_lane.sv
// Module: builds lane-replicated store data and the byte write-enable mask.
// Assumes big-endian lane order: offset 0 is the most significant lane, so
// enable bit (LANES-1-k) belongs to offset k. Enables are raised only when
// the caller says the write is allowed.
module sw_store_lane
    import sw_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int OFF_W = $clog2(LANES),
    localparam int HALF_W = 2 * BYTE_W
) (
    input  acc_size_e           size_i,
    input  logic [OFF_W-1:0]    off_i,
    input  logic                wr_ok_i,
    input  logic [DATA_W-1:0]   src_i,
    output logic [DATA_W-1:0]   wdata_o,
    output logic [LANES-1:0]    be_o
);

    logic [DATA_W-1:0] rep_byte;
    logic [DATA_W-1:0] rep_half;
    logic [LANES-1:0]  lane_hit;

    genvar g;
    generate
        // One slot per byte lane: copy of the low byte, and this lane's enable.
        for (g = 0; g < LANES; g++) begin : g_lane
            localparam int LANE_OFF = LANES - 1 - g;
            assign rep_byte[g*BYTE_W +: BYTE_W] = src_i[BYTE_W-1:0];

            // Decide whether the access covers lane g.
            always_comb begin
                unique case (size_i)
                    SZ_BYTE: lane_hit[g] = (int'(off_i) == LANE_OFF);
                    SZ_HALF: lane_hit[g] = ((int'(off_i) / 2) == (LANE_OFF / 2));
                    default: lane_hit[g] = 1'b1;
                endcase
            end
        end
        // One slot per halfword: copy of the low half.
        for (g = 0; g < LANES / 2; g++) begin : g_half
            assign rep_half[g*HALF_W +: HALF_W] = src_i[HALF_W-1:0];
        end
    endgenerate

    // Pick the replication that matches the access size.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: wdata_o = rep_byte;
            SZ_HALF: wdata_o = rep_half;
            default: wdata_o = src_i;
        endcase
    end

    // Gate the lane mask with the write permission.
    always_comb be_o = wr_ok_i ? lane_hit : '0;

endmodule

// File: rtl/sw_load_extract.sv
// Module: remembers the shape of a load for one cycle, then selects and
// widens the addressed lane of the returned memory word.
// Assumes the memory answers exactly one cycle after the request and
// big-endian lane numbering. Synchronous active-low reset.
module sw_load_extract
    import sw_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int OFF_W = $clog2(LANES),
    localparam int HALF_W = 2 * BYTE_W,
    localparam int HALVES = LANES / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  acc_size_e          size_i,
    input  logic               uns_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic [DATA_W-1:0]  rdata_i,
    output logic               valid_o,
    output logic [DATA_W-1:0]  data_o
);

    typedef struct packed {
        logic             live;
        acc_size_e        size;
        logic             uns;
        logic [OFF_W-1:0] off;
    } ld_ctrl_t;

    ld_ctrl_t pend_q;
    logic [BYTE_W-1:0] byte_at [LANES];
    logic [HALF_W-1:0] half_at [HALVES];
    logic [BYTE_W-1:0] sel_byte;
    logic [HALF_W-1:0] sel_half;

    // Capture the shape of an accepted load; idle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q.live <= take_i;
            pend_q.size <= size_i;
            pend_q.uns  <= uns_i;
            pend_q.off  <= off_i;
        end
    end

    genvar g;
    generate
        // Slice the returned word into lanes, offset 0 at the top.
        for (g = 0; g < LANES; g++) begin : g_byte
            assign byte_at[g] = rdata_i[DATA_W-1-g*BYTE_W -: BYTE_W];
        end
        for (g = 0; g < HALVES; g++) begin : g_half
            assign half_at[g] = rdata_i[DATA_W-1-g*HALF_W -: HALF_W];
        end
    endgenerate

    // Choose the lane named by the stored offset.
    always_comb begin
        sel_byte = byte_at[pend_q.off];
        sel_half = half_at[pend_q.off[OFF_W-1:1]];
    end

    // Widen the selection with sign or zero fill.
    always_comb begin
        unique case (pend_q.size)
            SZ_BYTE: data_o = {{(DATA_W-BYTE_W){sel_byte[BYTE_W-1] & ~pend_q.uns}}, sel_byte};
            SZ_HALF: data_o = {{(DATA_W-HALF_W){sel_half[HALF_W-1] & ~pend_q.uns}}, sel_half};
            default: data_o = rdata_i;
        endcase
    end

    assign valid_o = pend_q.live;

    // R7: a result appears only after an accepted load.
    assert_ld_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(take_i));

    // R3/R5: zero fill leaves the upper bits clear.
    assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && pend_q.uns && pend_q.size == SZ_BYTE) |-> (data_o[DATA_W-1:BYTE_W] == '0));

    // R2: sign fill copies the top bit of the selected byte.
    assert_sign_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !pend_q.uns && pend_q.size == SZ_BYTE) |->
        (data_o[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){data_o[BYTE_W-1]}}));

    // R6: a word result is the memory word itself.
    assert_word_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && pend_q.size == SZ_WORD) |-> (data_o == rdata_i));

endmodule

// File: rtl/sw_mem_aligner.sv
// Module: top of the sub-word aligner. Stores are shaped in the request
// cycle; loads are widened in the following cycle when memory data returns.
// Assumes a word-addressed memory with one-cycle read latency and that only
// the low address bits are presented here. Synchronous active-low reset.
module sw_mem_aligner
    import sw_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic               req_unsigned,
    input  logic [OFF_W-1:0]   req_offset,
    input  logic [DATA_W-1:0]  st_src,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [LANES-1:0]   mem_be,
    output logic               misaligned,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               ld_valid,
    output logic [DATA_W-1:0]  ld_data
);

    acc_size_e size_n;
    logic      off_bad;
    logic      store_ok;
    logic      load_ok;

    // Normalise the size code once for all sub-blocks.
    always_comb size_n = norm_size(req_size);

    sw_misalign_detect #(.OFF_W(OFF_W)) align_i (
        .size_i (size_n),
        .off_i  (req_offset),
        .bad_o  (off_bad)
    );

    // Qualify the access by direction and alignment.
    always_comb begin
        misaligned = req_valid & off_bad;
        store_ok   = req_valid & req_write & ~off_bad;
        load_ok    = req_valid & ~req_write & ~off_bad;
    end

    sw_store_lane #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) store_i (
        .size_i  (size_n),
        .off_i   (req_offset),
        .wr_ok_i (store_ok),
        .src_i   (st_src),
        .wdata_o (mem_wdata),
        .be_o    (mem_be)
    );

    sw_load_extract #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) load_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (load_ok),
        .size_i  (size_n),
        .uns_i   (req_unsigned),
        .off_i   (req_offset),
        .rdata_i (mem_rdata),
        .valid_o (ld_valid),
        .data_o  (ld_data)
    );

    // R11: a flagged access never writes.
    assert_misalign_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> (mem_be == '0));

    // R12: no request, no enables and no flag.
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (mem_be == '0 && !misaligned));

    // R8: a byte store enables exactly one lane.
    assert_byte_one_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && size_n == SZ_BYTE) |-> ($countones(mem_be) == 1));

    // R9: an aligned halfword store enables two lanes.
    assert_half_two_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && size_n == SZ_HALF && !misaligned) |-> ($countones(mem_be) == 2));

    // R10: an aligned word store enables every lane.
    assert_word_all_lanes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && size_n == SZ_WORD && !misaligned) |-> (&mem_be));

    // R11: a flagged load produces no result next cycle.
    assert_misalign_no_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (misaligned && !req_write) |=> !ld_valid);

endmodule

// File: tb/sw_mem_aligner_tb_top.sv
module sw_mem_aligner_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [1:0]  req_offset = 2'b00;
    logic [31:0] st_src = '0;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        misaligned;
    logic [31:0] mem_rdata = '0;
    logic        ld_valid;
    logic [31:0] ld_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sw_mem_aligner dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_offset(req_offset),
        .st_src(st_src), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .misaligned(misaligned), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
        .ld_data(ld_data)
    );

    function automatic bit model_bad(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'b00) return 1'b0;
        if (sz == 2'b01) return off[0];
        return off != 2'b00;
    endfunction

    function automatic logic [31:0] model_load(input logic [1:0] sz, input bit uns,
                                               input logic [1:0] off, input logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        if (sz == 2'b00) begin
            b = w >> (8 * (3 - int'(off)));
            return uns ? {24'h0, b} : {{24{b[7]}}, b};
        end
        if (sz == 2'b01) begin
            h = off[1] ? w[15:0] : w[31:16];
            return uns ? {16'h0, h} : {{16{h[15]}}, h};
        end
        return w;
    endfunction

    function automatic logic [3:0] model_be(input logic [1:0] sz, input logic [1:0] off);
        if (model_bad(sz, off)) return 4'h0;
        if (sz == 2'b00) return 4'b1000 >> off;
        if (sz == 2'b01) return off[1] ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] model_wdata(input logic [1:0] sz, input logic [31:0] s);
        if (sz == 2'b00) return {4{s[7:0]}};
        if (sz == 2'b01) return {2{s[15:0]}};
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Load: request at a falling edge, memory word and result one cycle later.
    task automatic do_load(input logic [1:0] sz, input bit uns, input logic [1:0] off,
                           input logic [31:0] w, input string req);
        bit bad;
        bad = model_bad(sz, off);
        req_valid = 1'b1; req_write = 1'b0; req_size = sz;
        req_unsigned = uns; req_offset = off;
        #1;
        check(misaligned == bad, "R11 load flag", {31'h0, misaligned}, {31'h0, bad});
        check(mem_be == 4'h0, "R11 load no write", {28'h0, mem_be}, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        mem_rdata = w;
        #1;
        check(ld_valid == !bad, "R7 ld_valid", {31'h0, ld_valid}, {31'h0, !bad});
        if (!bad)
            check(ld_data == model_load(sz, uns, off, w), req, ld_data, model_load(sz, uns, off, w));
        @(negedge clk);
    endtask

    // Store: outputs checked in the request cycle.
    task automatic do_store(input logic [1:0] sz, input logic [1:0] off,
                            input logic [31:0] s, input string req);
        bit bad;
        bad = model_bad(sz, off);
        req_valid = 1'b1; req_write = 1'b1; req_size = sz;
        req_unsigned = 1'b0; req_offset = off; st_src = s;
        #1;
        check(misaligned == bad, "R11 store flag", {31'h0, misaligned}, {31'h0, bad});
        check(mem_be == model_be(sz, off), req, {28'h0, mem_be}, {28'h0, model_be(sz, off)});
        if (!bad)
            check(mem_wdata == model_wdata(sz, s), req, mem_wdata, model_wdata(sz, s));
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(ld_valid == 1'b0, "R7 no result after store", {31'h0, ld_valid}, 32'h0);
        @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check(ld_valid == 1'b0, "R1 reset", {31'h0, ld_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ld_valid == 1'b0, "R1 after reset", {31'h0, ld_valid}, 32'h0);
        #1;
        check(mem_be == 4'h0 && !misaligned, "R12 idle", {27'h0, misaligned, mem_be}, 32'h0);
        @(negedge clk);

        // Directed loads over a word with distinct lanes.
        for (int k = 0; k < 4; k++) begin
            do_load(2'b00, 1'b0, 2'(k), 32'h8A7B_C56D, "R2 signed byte");
            do_load(2'b00, 1'b1, 2'(k), 32'h8A7B_C56D, "R3 unsigned byte");
        end
        do_load(2'b01, 1'b0, 2'd0, 32'h9234_5678, "R4 signed half off0");
        do_load(2'b01, 1'b0, 2'd2, 32'h1234_F678, "R4 signed half off2");
        do_load(2'b01, 1'b0, 2'd2, 32'hF234_5678, "R4 positive half");
        do_load(2'b01, 1'b1, 2'd0, 32'h9234_5678, "R5 unsigned half off0");
        do_load(2'b01, 1'b1, 2'd2, 32'h1234_F678, "R5 unsigned half off2");
        do_load(2'b10, 1'b1, 2'd0, 32'hDEAD_BEEF, "R6 word ignores unsigned");
        do_load(2'b11, 1'b0, 2'd0, 32'hCAFE_0001, "R6 spare size as word");
        do_load(2'b01, 1'b0, 2'd1, 32'h1111_2222, "R11 odd half load");
        do_load(2'b10, 1'b0, 2'd2, 32'h1111_2222, "R11 offset word load");

        // Directed stores with distinct upper source bytes.
        for (int k = 0; k < 4; k++)
            do_store(2'b00, 2'(k), 32'hA1B2_C3D4, "R8 byte store");
        do_store(2'b01, 2'd0, 32'hA1B2_C3D4, "R9 half store off0");
        do_store(2'b01, 2'd2, 32'hA1B2_C3D4, "R9 half store off2");
        do_store(2'b10, 2'd0, 32'hA1B2_C3D4, "R10 word store");
        do_store(2'b11, 2'd0, 32'h0F1E_2D3C, "R10 spare size store");
        do_store(2'b01, 2'd3, 32'hA1B2_C3D4, "R11 odd half store");
        do_store(2'b10, 2'd1, 32'hA1B2_C3D4, "R11 offset word store");

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            logic [1:0]  sz;
            logic [1:0]  off;
            logic [31:0] v;
            bit wr;
            bit uns;
            sz  = 2'($urandom_range(0, 3));
            off = 2'($urandom_range(0, 3));
            v   = $urandom;
            wr  = 1'($urandom_range(0, 1));
            uns = 1'($urandom_range(0, 1));
            if (wr) do_store(sz, off, v, "R8 R9 R10 random store");
            else    do_load(sz, uns, off, v, "R2 R3 R4 R5 R6 random load");
            if ($urandom_range(0, 3) == 0) begin
                #1;
                check(mem_be == 4'h0 && !misaligned, "R12 random idle", {27'h0, misaligned, mem_be}, 32'h0);
                @(negedge clk);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule